// File: doc/BRIEF.md
# Receive Cut-Through Frame FIFO

This block buffers a byte stream from a MAC receiver and passes it to a consumer as framed bytes. The writer marks the first and last byte of each frame. On the last byte it can raise an error flag. The buffer holds each incoming frame back from the read side until the frame either reaches a programmable byte threshold or ends, whichever comes first. Once part of a frame has been handed to the read side, that frame can no longer be withdrawn.

The block filters frames that are still held back when their end arrives. A short frame (fewer than 64 bytes) is removed unless short-frame forwarding is enabled. A frame that ends with the error flag is removed unless error forwarding is enabled. To remove a frame, the write pointer moves back to where the frame began, so none of its bytes ever become readable.

A frame that was already released and is later found to be bad is still delivered in full, with an error marker on its last byte. A saturating counter records each frame that was removed. When the buffer runs out of room, a held-back frame is dropped. A released frame is cut short instead: its last stored byte is marked as the end and as an error.

Top module: `rx_cutthru_fifo`

## Requirements
- R1: After reset, out_valid is low and drop_count is zero.
- R2: thr_code selects the release threshold: 2'b00 = 64 bytes, 2'b01 = 32, 2'b10 = 96, 2'b11 = 128. When a frame's byte count reaches the threshold on a byte that is not its last, the frame is released, and out_valid rises in the cycle after that byte is written. Every later byte of the frame is readable in the cycle after it is written.
- R3: A frame that ends before it reaches the threshold is judged on its last byte. If it is kept, all of its bytes become readable together in the cycle after that last byte.
- R4: A frame that has not been released and is shorter than 64 bytes is removed entirely when fwd_small is 0. When fwd_small is 1, the same frame is delivered intact with out_err low.
- R5: A frame that has not been released and ends with in_err high is removed entirely when fwd_err is 0. When fwd_err is 1, it is delivered with out_err high on its last byte.
- R6: A frame that has been released is never removed. Its last byte carries out_err = 1 if in_err was high, or if the frame is shorter than 64 bytes while fwd_small is 0.
- R7: drop_count increases by exactly one for each removed frame and stays at its all-ones value once it gets there.
- R8: A byte counts as overflowing when the buffer is full, or when only one slot is free and the byte is not a frame end. An overflowing byte of a held-back frame removes the whole frame and counts one drop. An overflowing byte of a released frame is stored as that frame's end with out_err high. In both cases the rest of the frame is ignored until the next start.
- R9: The read side delivers bytes in write order, with out_sof on each frame's first byte and out_eof on its last. While out_valid is high and out_ready is low, out_valid and the presented byte do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write byte strobe |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame ended in error (sampled with in_eof) |
| in_data | input | 8 | Write byte |
| thr_code | input | 2 | Release threshold selector |
| fwd_small | input | 1 | Deliver frames shorter than 64 bytes |
| fwd_err | input | 1 | Deliver frames that end in error |
| out_ready | input | 1 | Consumer accepts the presented byte |
| out_valid | output | 1 | A readable byte is presented |
| out_data | output | 8 | Presented byte |
| out_sof | output | 1 | Presented byte starts a frame |
| out_eof | output | 1 | Presented byte ends a frame |
| out_err | output | 1 | Frame delivered with an error marker |
| drop_count | output | CNT_W | Saturating count of removed frames |

## Verification
The assertions check, on every cycle, the following properties:
- the read-side hold,
- the rule that a removal leaves no bytes pending behind the visible point,
- that out_valid follows each release,
- the occupancy bound,
- the step-or-hold behaviour of the counter, including saturation.

Some behaviours can only be shown by the bench's scenarios, which compare the design on every clock against a reference model built on queues:
- the exact release point for each threshold code,
- which frames the two forwarding enables keep or remove,
- the error marker on frames that were released and then went bad,
- both kinds of overflow.

// File: rtl/rxcf_pkg.sv
package rxcf_pkg;
  localparam int unsigned MIN_FRAME = 64;

  typedef struct packed {
    logic       err;
    logic       eof;
    logic       sof;
    logic [7:0] data;
  } rxcf_ent_t;

  // release threshold in bytes for a threshold code
  function automatic logic [7:0] thr_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd64;
      2'b01:   return 8'd32;
      2'b10:   return 8'd96;
      default: return 8'd128;
    endcase
  endfunction

  // saturating frame length step
  function automatic logic [7:0] len_step(input logic [7:0] len);
    return (len == 8'hFF) ? len : len + 8'd1;
  endfunction
endpackage

// File: rtl/rxcf_store.sv
module rxcf_store
  import rxcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic      clk,
  input  logic      we,
  input  logic [AW-1:0] waddr,
  input  rxcf_ent_t wdata,
  input  logic [AW-1:0] raddr,
  output rxcf_ent_t rdata
);
  rxcf_ent_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxcf_verdict.sv
module rxcf_verdict
  import rxcf_pkg::*;
(
  input  logic [7:0] frame_len,
  input  logic       frame_err,
  input  logic       released,
  input  logic       fwd_small,
  input  logic       fwd_err,
  output logic       discard,
  output logic       mark_err
);
  logic small_bad, err_bad;

  always_comb begin
    small_bad = (frame_len < 8'(MIN_FRAME)) && !fwd_small;
    err_bad   = frame_err && !fwd_err;
    discard   = !released && (small_bad || err_bad);
    mark_err  = frame_err || small_bad;
  end
endmodule

// File: rtl/rxcf_sat_cnt.sv
module rxcf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != MAXV) count <= count + 1'b1;
  end

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc && count != MAXV |=> count == $past(count) + 1'b1);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc || count == MAXV |=> $stable(count));
endmodule

// File: rtl/rx_cutthru_fifo.sv
module rx_cutthru_fifo
  import rxcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  input  logic [7:0]       in_data,
  input  logic [1:0]       thr_code,
  input  logic             fwd_small,
  input  logic             fwd_err,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_err,
  output logic [CNT_W-1:0] drop_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] wr_ptr, rd_ptr, vis_ptr, frm_start;
  logic [7:0]    len_q;
  logic          released_q, skip_q;

  // per-byte view of the frame being written
  logic [7:0]    new_len;
  logic [PW-1:0] base_start, occ;
  logic          strm, skip_now, take, ovf;
  logic          evt_drop_ovf, evt_trunc, evt_end, evt_drop_end, evt_drop;
  logic          evt_release, evt_commit, evt_write, evt_pop;
  logic          discard, mark_err;
  rxcf_ent_t     wdata, rdata;

  assign new_len    = in_sof ? 8'd1 : len_step(len_q);
  assign base_start = in_sof ? wr_ptr : frm_start;
  assign strm       = in_sof ? 1'b0 : released_q;
  assign skip_now   = in_sof ? 1'b0 : skip_q;
  assign occ        = wr_ptr - rd_ptr;
  assign take       = in_valid && !skip_now;
  assign ovf        = (occ == FULL) || (occ == LAST && !in_eof);

  assign evt_drop_ovf = take && ovf && !strm;
  assign evt_trunc    = take && ovf && strm;
  assign evt_end      = take && !ovf && in_eof;
  assign evt_drop_end = evt_end && discard;
  assign evt_drop     = evt_drop_ovf || evt_drop_end;
  assign evt_release  = take && !ovf && !in_eof &&
                        (strm || new_len == thr_bytes(thr_code));
  assign evt_commit   = evt_trunc || (evt_end && !discard) || evt_release;
  assign evt_write    = take && !evt_drop;
  assign evt_pop      = out_valid && out_ready;

  rxcf_verdict u_verdict (
    .frame_len (new_len),
    .frame_err (in_err),
    .released  (strm),
    .fwd_small (fwd_small),
    .fwd_err   (fwd_err),
    .discard   (discard),
    .mark_err  (mark_err)
  );

  always_comb begin
    wdata.data = in_data;
    wdata.sof  = in_sof;
    wdata.eof  = in_eof || evt_trunc;
    wdata.err  = evt_trunc || (in_eof && mark_err);
  end

  rxcf_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (evt_write),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (wdata),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (rdata)
  );

  rxcf_sat_cnt #(.W(CNT_W)) u_drops (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (evt_drop),
    .count (drop_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      vis_ptr    <= '0;
      frm_start  <= '0;
      len_q      <= '0;
      released_q <= 1'b0;
      skip_q     <= 1'b0;
    end else begin
      if (evt_pop) rd_ptr <= rd_ptr + 1'b1;
      if (take) begin
        frm_start <= base_start;
        len_q     <= new_len;
        skip_q    <= evt_drop_ovf || evt_trunc;
        if (evt_drop) begin
          wr_ptr     <= base_start;
          released_q <= 1'b0;
        end else begin
          wr_ptr     <= wr_ptr + 1'b1;
          released_q <= evt_release;
        end
        if (evt_commit) vis_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  assign out_valid = rd_ptr != vis_ptr;
  assign out_data  = rdata.data;
  assign out_sof   = rdata.sof;
  assign out_eof   = rdata.eof;
  assign out_err   = rdata.err;

  // R9: presented byte holds under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_eof) && $stable(out_sof));
  // R2: a release makes data readable next cycle
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    evt_release |=> out_valid);
  // R8: a removal leaves nothing pending beyond the visible point
  a_r8_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> wr_ptr == vis_ptr);
  // R6: a released frame is never removed at its end
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop_end |-> !(released_q && !in_sof));
  // R8: occupancy never exceeds the storage
  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) <= FULL && (vis_ptr - rd_ptr) <= FULL);
endmodule

// File: tb/rx_cutthru_fifo_tb.sv
module rx_cutthru_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int CNT_W = 3;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic [1:0] thr_code = 0;
  logic fwd_small = 0, fwd_err = 0, out_ready = 1;
  logic out_valid, out_sof, out_eof, out_err;
  logic [7:0] out_data;
  logic [CNT_W-1:0] drop_count;

  int errors = 0, checks = 0;

  rx_cutthru_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
    .thr_code(thr_code), .fwd_small(fwd_small), .fwd_err(fwd_err),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
    .drop_count(drop_count));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: entries {err,eof,sof,data}
  logic [10:0] vis_q[$];
  logic [10:0] pend[$];
  bit released, skipping;
  int len, drops, frame_bytes;
  int rel_at = -1;
  int frames_out = 0, err_frames_out = 0, cur_out_len = 0, last_out_len = 0;
  bit last_out_err;

  function automatic int thr_of(input logic [1:0] c);
    int t [4] = '{64, 32, 96, 128};
    return t[c];
  endfunction

  task automatic publish();
    while (pend.size() > 0) vis_q.push_back(pend.pop_front());
  endtask

  always @(posedge clk) begin
    // observe DUT pops (outputs still hold pre-edge values)
    if (rst_n && out_valid && out_ready) begin
      cur_out_len++;
      if (out_eof) begin
        frames_out++;
        if (out_err) err_frames_out++;
        last_out_len = cur_out_len;
        last_out_err = out_err;
        cur_out_len = 0;
      end
    end
    if (!rst_n) begin
      vis_q.delete(); pend.delete();
      released = 0; skipping = 0; len = 0; drops = 0; frame_bytes = 0;
    end else begin
      int occ;
      bit pop;
      occ = vis_q.size() + pend.size();
      pop = (vis_q.size() > 0) && out_ready;
      if (in_valid) begin
        frame_bytes = in_sof ? 1 : frame_bytes + 1;
        if (in_sof) begin
          released = 0; skipping = 0; len = 0; pend.delete();
        end
        if (!skipping) begin
          int nl;
          bit ovf;
          nl = len + 1;
          ovf = (occ == DEPTH) || (occ == DEPTH - 1 && !in_eof);
          if (ovf && !released) begin
            pend.delete(); skipping = 1;
            if (drops < MAXC) drops++;
          end else if (ovf) begin
            vis_q.push_back({1'b1, 1'b1, 1'b0, in_data});
            skipping = 1; released = 0;
          end else if (in_eof) begin
            bit small_bad, bad;
            small_bad = (nl < 64) && !fwd_small;
            bad = small_bad || (in_err && !fwd_err);
            if (!released && bad) begin
              pend.delete();
              if (drops < MAXC) drops++;
            end else begin
              pend.push_back({in_err | small_bad, 1'b1, in_sof, in_data});
              publish();
            end
            released = 0;
          end else begin
            pend.push_back({1'b0, 1'b0, in_sof, in_data});
            len = nl;
            if (released || nl == thr_of(thr_code)) begin
              publish(); released = 1;
            end
          end
        end
      end
      if (pop) void'(vis_q.pop_front());
    end
    #2;
    if (rst_n) begin
      check(out_valid == (vis_q.size() > 0), "R9 valid", out_valid, vis_q.size() > 0);
      if (out_valid && vis_q.size() > 0)
        check({out_err, out_eof, out_sof, out_data} == vis_q[0], "R9 byte",
              {out_err, out_eof, out_sof, out_data}, vis_q[0]);
      check(drop_count == CNT_W'(drops), "R7 count", drop_count, drops);
      if (out_valid && rel_at < 0) rel_at = frame_bytes;
    end
  end

  task automatic send_frame(input int n, input bit err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_err = err && (i == n - 1); in_data = 8'($urandom);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    repeat (300) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] c, input bit fs, input bit fe);
    @(negedge clk);
    thr_code = c; fwd_small = fs; fwd_err = fe;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int f0, d0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 valid", out_valid, 0);
    check(drop_count == 0, "R1 count", drop_count, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && drop_count == 0, "R1 after release", out_valid, 0);

    // R2: release point per threshold code
    for (int c = 0; c < 4; c++) begin
      cfg(2'(c), 1, 1);
      rel_at = -1;
      send_frame(140, 0);
      drain();
      check(rel_at == thr_of(2'(c)), "R2 threshold", rel_at, thr_of(2'(c)));
    end

    // R3: short frame released at its end
    cfg(2'b00, 1, 1);
    rel_at = -1; f0 = frames_out;
    send_frame(10, 0); drain();
    check(rel_at == 10, "R3 end release", rel_at, 10);
    check(frames_out == f0 + 1 && last_out_len == 10, "R3 delivered", last_out_len, 10);

    // R4: undersized handling
    f0 = frames_out; d0 = drop_count;
    send_frame(20, 0); drain();
    check(frames_out == f0 + 1 && !last_out_err, "R4 forwarded", frames_out - f0, 1);
    cfg(2'b00, 0, 1);
    f0 = frames_out;
    send_frame(20, 0); drain();
    check(frames_out == f0, "R4 removed", frames_out - f0, 0);
    check(drop_count == CNT_W'(d0 + 1), "R4 drop counted", drop_count, d0 + 1);

    // R5: error frames under threshold 128
    cfg(2'b11, 1, 0);
    f0 = frames_out; d0 = drop_count;
    send_frame(80, 1); drain();
    check(frames_out == f0 && drop_count == CNT_W'(d0 + 1), "R5 removed", frames_out - f0, 0);
    cfg(2'b11, 1, 1);
    send_frame(80, 1); drain();
    check(frames_out == f0 + 1 && last_out_err, "R5 delivered marked", last_out_err, 1);

    // R6: released frames survive, with marker
    cfg(2'b01, 0, 0);
    f0 = frames_out; d0 = drop_count;
    send_frame(40, 0); drain();
    check(last_out_len == 40 && last_out_err, "R6 short released", last_out_len, 40);
    send_frame(50, 1); drain();
    check(last_out_len == 50 && last_out_err, "R6 error released", last_out_len, 50);
    check(frames_out == f0 + 2 && drop_count == CNT_W'(d0), "R6 no drop", frames_out - f0, 2);

    // R8: overflow of a held-back frame
    cfg(2'b11, 1, 1);
    out_ready = 0;
    f0 = frames_out; d0 = drop_count;
    send_frame(100, 0); send_frame(100, 0); send_frame(100, 0);
    drain();
    check(frames_out == f0 + 2, "R8 held overflow", frames_out - f0, 2);
    check(drop_count == CNT_W'(d0 + 1), "R8 drop counted", drop_count, d0 + 1);

    // R8: overflow of a released frame truncates
    cfg(2'b01, 1, 1);
    out_ready = 0;
    f0 = frames_out;
    send_frame(300, 0); drain();
    check(frames_out == f0 + 1 && last_out_len == DEPTH, "R8 truncated", last_out_len, DEPTH);
    check(last_out_err == 1, "R8 truncation marker", last_out_err, 1);

    // mixed traffic with back-pressure, model compared every cycle
    for (int k = 0; k < 120; k++) begin
      cfg(2'($urandom), 1'($urandom), 1'($urandom));
      fork
        send_frame(1 + ($urandom % 150), 1'($urandom % 4 == 0));
        repeat (60) begin @(negedge clk); out_ready = 1'($urandom % 3 != 0); end
      join
    end
    drain();

    // R7: saturation
    cfg(2'b00, 0, 1);
    for (int k = 0; k < MAXC + 2; k++) send_frame(5, 0);
    drain();
    check(drop_count == CNT_W'(MAXC), "R7 saturated", drop_count, MAXC);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule